// File: doc/BRIEF.md
# Return Address Shadow Stack

This block runs beside the call/return logic of an instruction pipeline and keeps its own protected copy of every return address. Each retired call writes the return address into a small on-chip LIFO, alongside the copy on the ordinary stack. Each retired return takes the top entry off the LIFO and compares it with the address the pipeline popped from the ordinary stack. When the two differ, the block reports a control-flow violation. No change to the running program is needed, because the block reacts only to call and return events.

The LIFO holds return addresses and nothing else. Ordinary loads and stores cannot reach it. A separate check watches the data-access address and raises an access fault when a regular access lands in the protected address window. The block only compares and flags. It never supplies a predicted return target. A synchronous flush empties the stack and clears every status flag.

Top module: `ret_shadow_stack`

## Requirements
- R1: A call with no return in the same cycle stores its address as the new top entry, and `depth_o` rises by one in the next cycle, provided the stack was not full.
- R2: A return whose address equals the top entry removes that entry, lowers `depth_o` by one and leaves `violation_o` low.
- R3: A return whose address differs from the top entry drives `violation_o` high for the single cycle after the return strobe. It removes exactly one entry, so the next return is compared with the entry below.
- R4: Entries come back in last-in first-out order across nested calls, and each entry holds only the full return address.
- R5: A return while the stack is empty raises `violation_o` in the next cycle and sets the sticky `underflow_o`. `depth_o` stays 0.
- R6: A call while the stack holds DEPTH entries sets the sticky `overflow_o` and drops the address. `depth_o` stays at DEPTH and the stored entries are unchanged.
- R7: When a call and a return arrive in the same cycle, the return is compared and popped first, then the call is pushed. A full stack therefore accepts the call without overflow, and an empty stack reports underflow and still stores the call.
- R8: A data access whose address lies in [PROT_BASE, PROT_BASE+PROT_BYTES) drives `acc_fault_o` high in the next cycle. An access outside that window leaves `acc_fault_o` low.
- R9: `flush_i` empties the stack and clears `violation_o`, `overflow_o`, `underflow_o` and `acc_fault_o` in the next cycle. It takes priority over any call, return or access in the same cycle.
- R10: After reset, `depth_o` is 0 and every flag output is low.
- R11: `violation_o` is high only in a cycle that follows a return strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Synchronous empty-and-clear |
| call_i | input | 1 | Call retired this cycle |
| call_addr_i | input | ADDR_W | Return address saved by the call |
| ret_i | input | 1 | Return retired this cycle |
| ret_addr_i | input | ADDR_W | Address popped from the ordinary stack |
| acc_i | input | 1 | Regular data load or store this cycle |
| acc_addr_i | input | ADDR_W | Address of that data access |
| violation_o | output | 1 | One-cycle pulse on a mismatch or an empty pop |
| overflow_o | output | 1 | Sticky: a call was dropped on a full stack |
| underflow_o | output | 1 | Sticky: a return arrived on an empty stack |
| depth_o | output | $clog2(DEPTH+1) | Number of stored entries |
| acc_fault_o | output | 1 | Regular access hit the protected window |

## Verification
The comparison is tried with matching returns, returns with a single flipped bit, and deeply nested call chains. These separate a correct compare from one that checks only part of the address, and a true LIFO from a queue. Driving the stack to both ends, and holding call and return together at empty, at full and in between, shows whether the return-before-call order and the sticky flags are right. Random mixes that include flushes and accesses at the window edges and just outside them show off-by-one errors in the region test and whether flush wins over the other inputs.

// File: rtl/ss_pkg.sv
`timescale 1ns/1ps
package ss_pkg;
  // Wrap-safe window test: true when addr lies in [base, base+bytes).
  function automatic logic in_window(input logic [63:0] addr,
                                     input logic [63:0] base,
                                     input logic [63:0] bytes);
    logic [63:0] off;
    off = addr - base;
    return off < bytes;
  endfunction
endpackage

// File: rtl/ss_store.sv
`timescale 1ns/1ps
module ss_store #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] widx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [PTR_W-1:0] ridx_i,
  output logic [W-1:0]     rdata_o
);
  // Plain array, no reset: maps onto distributed RAM with an async read port.
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/ss_ctrl.sv
`timescale 1ns/1ps
module ss_ctrl #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             flush_i,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic [W-1:0]     ret_addr_i,
  input  logic [W-1:0]     top_data_i,
  output logic             we_o,
  output logic [PTR_W-1:0] widx_o,
  output logic [PTR_W-1:0] ridx_o,
  output logic [CNT_W-1:0] depth_o,
  output logic             violation_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] depth_q, depth_mid;
  logic             do_pop, empty_ret, mismatch, full_call, do_push;
  logic             viol_q, ovf_q, unf_q;

  // The return is resolved first and the call sees the depth it leaves behind.
  always_comb begin
    do_pop    = ret_i && (depth_q != '0);
    empty_ret = ret_i && (depth_q == '0);
    mismatch  = do_pop && (top_data_i != ret_addr_i);
    depth_mid = do_pop ? depth_q - CNT_W'(1) : depth_q;
    full_call = call_i && (depth_mid == FULL);
    do_push   = call_i && !full_call;
  end

  assign ridx_o = PTR_W'(depth_q - CNT_W'(1));
  assign widx_o = depth_mid[PTR_W-1:0];
  assign we_o   = do_push && !flush_i && !rst_i;

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) begin
      depth_q <= '0;
      viol_q  <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      depth_q <= depth_mid + CNT_W'(do_push);
      viol_q  <= mismatch || empty_ret;
      ovf_q   <= ovf_q || full_call;
      unf_q   <= unf_q || empty_ret;
    end
  end

  assign depth_o     = depth_q;
  assign violation_o = viol_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  // R1
  push_grow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (call_i && !ret_i && !flush_i && depth_q != FULL) |=> depth_q == $past(depth_q) + CNT_W'(1));
  // R5
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ret_i && depth_q == '0 && !flush_i) |=> (underflow_o && violation_o && depth_q <= CNT_W'(1)));
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    depth_q <= FULL);
  // R6
  sticky_ovf_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (overflow_o && !flush_i) |=> overflow_o);
  // R9
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |=> (depth_q == '0 && !overflow_o && !underflow_o && !violation_o));
  // R11
  viol_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    violation_o |-> $past(ret_i));
endmodule

// File: rtl/ss_guard.sv
`timescale 1ns/1ps
module ss_guard #(
  parameter int          W          = 32,
  parameter logic [63:0] PROT_BASE  = 64'hFFFF_0000,
  parameter logic [63:0] PROT_BYTES = 64'h1000
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         flush_i,
  input  logic         acc_i,
  input  logic [W-1:0] acc_addr_i,
  output logic         acc_fault_o
);
  import ss_pkg::*;

  logic hit;
  assign hit = acc_i && in_window(64'(acc_addr_i), PROT_BASE, PROT_BYTES);

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) acc_fault_o <= 1'b0;
    else                  acc_fault_o <= hit;
  end

  // R8
  fault_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    acc_fault_o |-> $past(acc_i));
endmodule

// File: rtl/ret_shadow_stack.sv
`timescale 1ns/1ps
module ret_shadow_stack #(
  parameter int          ADDR_W     = 32,
  parameter int          DEPTH      = 16,
  parameter logic [63:0] PROT_BASE  = 64'hFFFF_0000,
  parameter logic [63:0] PROT_BYTES = 64'h1000,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              flush_i,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_addr_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  input  logic              acc_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              violation_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              acc_fault_o
);
  logic              we;
  logic [PTR_W-1:0]  widx, ridx;
  logic [ADDR_W-1:0] top_data;

  ss_store #(.W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (we),
    .widx_i  (widx),
    .wdata_i (call_addr_i),
    .ridx_i  (ridx),
    .rdata_o (top_data)
  );

  ss_ctrl #(.W(ADDR_W), .DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .flush_i     (flush_i),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .ret_addr_i  (ret_addr_i),
    .top_data_i  (top_data),
    .we_o        (we),
    .widx_o      (widx),
    .ridx_o      (ridx),
    .depth_o     (depth_o),
    .violation_o (violation_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  ss_guard #(.W(ADDR_W), .PROT_BASE(PROT_BASE), .PROT_BYTES(PROT_BYTES)) u_guard (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .flush_i     (flush_i),
    .acc_i       (acc_i),
    .acc_addr_i  (acc_addr_i),
    .acc_fault_o (acc_fault_o)
  );
endmodule

// File: tb/sim_ret_shadow_stack.sv
`timescale 1ns/1ps
module sim_ret_shadow_stack;
  localparam int          AW    = 32;
  localparam int          DEPTH = 16;
  localparam int          CW    = $clog2(DEPTH + 1);
  localparam logic [31:0] PBASE = 32'hFFFF_0000;
  localparam logic [31:0] PSIZE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst = 1'b1, flush = 1'b0, call = 1'b0, ret = 1'b0, acc = 1'b0;
  logic [AW-1:0] call_addr = '0, ret_addr = '0, acc_addr = '0;
  logic viol, ovf, unf, afault;
  logic [CW-1:0] depth;

  always #2 clk = ~clk;

  ret_shadow_stack #(.ADDR_W(AW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_i(rst), .flush_i(flush),
    .call_i(call), .call_addr_i(call_addr),
    .ret_i(ret), .ret_addr_i(ret_addr),
    .acc_i(acc), .acc_addr_i(acc_addr),
    .violation_o(viol), .overflow_o(ovf), .underflow_o(unf),
    .depth_o(depth), .acc_fault_o(afault)
  );

  // Behavioural reference state
  logic [AW-1:0] q[$];
  bit m_viol, m_ovf, m_unf, m_af;
  int vectors = 0, miscompares = 0;

  task automatic cmp(string req, string what, longint act, longint exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    vectors++;
    cmp(req, "depth", depth, q.size());
    cmp(req, "violation", viol, m_viol);
    cmp(req, "overflow", ovf, m_ovf);
    cmp(req, "underflow", unf, m_unf);
    cmp(req, "acc_fault", afault, m_af);
  endtask

  // Apply one cycle of stimulus at a falling edge, update the model, compare at the next falling edge.
  task automatic step(string req, bit c, logic [AW-1:0] ca, bit r, logic [AW-1:0] ra,
                      bit a = 0, logic [AW-1:0] aa = '0, bit f = 0);
    call = c; call_addr = ca; ret = r; ret_addr = ra; acc = a; acc_addr = aa; flush = f;
    if (f) begin
      q.delete(); m_viol = 0; m_ovf = 0; m_unf = 0; m_af = 0;
    end else begin
      m_viol = 0;
      m_af = a && ((aa - PBASE) < PSIZE);
      if (r) begin
        if (q.size() == 0) begin m_viol = 1; m_unf = 1; end
        else if (q.pop_back() != ra) m_viol = 1;
      end
      if (c) begin
        if (q.size() == DEPTH) m_ovf = 1;
        else q.push_back(ca);
      end
    end
    @(posedge clk);
    @(negedge clk);
    call = 0; ret = 0; acc = 0; flush = 0;
    compare_all(req);
  endtask

  task automatic idle(string req);
    step(req, 0, '0, 0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [AW-1:0] top;
    // R10 reset state
    repeat (3) @(negedge clk);
    rst = 0;
    compare_all("R10");

    // R1 pushes, R2 matching pops
    step("R1", 1, 32'h1000_0004, 0, '0);
    step("R1", 1, 32'h1000_0100, 0, '0);
    step("R1", 1, 32'h2000_0008, 0, '0);
    step("R2", 0, '0, 1, 32'h2000_0008);
    idle("R2");

    // R4 nested LIFO order
    for (int i = 0; i < 6; i++) step("R4", 1, 32'hA000_0000 + 32'(i * 16), 0, '0);
    for (int i = 5; i >= 0; i--) step("R4", 0, '0, 1, 32'hA000_0000 + 32'(i * 16));

    // R3 single-bit mismatch, then R11 that the pulse ends
    step("R3", 0, '0, 1, 32'h1000_0100 ^ 32'h8000_0000);
    idle("R11");
    step("R3", 0, '0, 1, 32'h1000_0004);

    // R5 pop while empty, stays sticky
    step("R5", 0, '0, 1, 32'h1234_5678);
    idle("R5");
    step("R9", 1, 32'h5555_0000, 1, '0, 0, '0, 1);

    // R6 fill, overflow, then unchanged contents
    for (int i = 0; i < DEPTH; i++) step("R6", 1, 32'hC000_0000 + 32'(i), 0, '0);
    step("R6", 1, 32'hDEAD_BEEF, 0, '0);
    idle("R6");
    // R7 on full stack: pop then push, no new overflow requirement issue
    step("R7", 1, 32'hE000_0001, 1, 32'hC000_0000 + 32'(DEPTH - 1));
    step("R7", 0, '0, 1, 32'hE000_0001);
    for (int i = DEPTH - 2; i >= 0; i--) step("R6", 0, '0, 1, 32'hC000_0000 + 32'(i));
    // R7 on empty stack: underflow yet call stored
    step("R7", 1, 32'hF000_0010, 1, 32'h0);
    step("R7", 0, '0, 1, 32'hF000_0010);
    step("R9", 0, '0, 0, '0, 0, '0, 1);

    // R8 protected window edges
    step("R8", 0, '0, 0, '0, 1, PBASE);
    step("R8", 0, '0, 0, '0, 1, PBASE + PSIZE - 1);
    step("R8", 0, '0, 0, '0, 1, PBASE + PSIZE);
    step("R8", 0, '0, 0, '0, 1, PBASE - 1);
    step("R8", 0, '0, 0, '0, 0, PBASE);
    step("R8", 0, '0, 0, '0, 1, PBASE + 32'h10);
    // R9 flush wins over call, return and access
    step("R9", 1, 32'h0BAD_0000, 0, '0);
    step("R9", 1, 32'h0BAD_0001, 1, 32'h0, 1, PBASE, 1);

    // Random mix of all inputs
    for (int n = 0; n < 3000; n++) begin
      bit c, r, a, f;
      logic [AW-1:0] ra;
      c = ($urandom % 3) == 0;
      r = ($urandom % 3) == 0;
      a = ($urandom % 4) == 0;
      f = ($urandom % 97) == 0;
      top = (q.size() != 0) ? q[$] : 32'h0;
      ra = (($urandom % 5) == 0) ? (top ^ (32'h1 << ($urandom % 32))) : top;
      step("R4", c, $urandom, r, ra, a, PBASE - 32'h800 + ($urandom % 32'h2000), f);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule